// File: doc/BRIEF.md
# Dual DAC Parallel Bus Write Sequencer

This block sits on the host side of a dual-channel, parallel-input DAC. It takes commands through a valid/ready handshake and runs the DAC's bus pins: data word, channel-select address, active-low chip select, one active-low load strobe per channel and an active-low reset. Each command runs as a series of clock-counted phases. Every phase is at least as long as the interface minimum it serves.

All intervals are given in nanoseconds and turned into cycle counts from the clock period (`CLK_PERIOD_PS`). A parameter (`HIGH_SUPPLY`) picks the low-supply or the high-supply set of minimums. A host can write one channel's input register and then load it. It can also write both channels and then update them together with one combined load command.

Commands are encoded on `cmdOp`: 0 write A, 1 write B, 2 write and load A, 3 write and load B, 4 load A, 5 load B, 6 load both, 7 pulse reset. In the defaults below, T is the clock period and ceil(x/T) is rounded up, with a minimum of 1. With the default low-supply set and a 4 ns clock, the counts are: CS = max(ceil(45/T), ceil(30/T)) = 12, DH = ceil(20/T) = 5, LS = ceil(20/T) = 5, LW = ceil(30/T) = 8, LH = ceil(10/T) = 3, RW = ceil(40/T) = 10.

Top module: `dac_bus_sequencer`

## Requirements
- R1: While reset is held and after it is released, `dacCsN`, `dacLdAN`, `dacLdBN` and `dacRstN` are high, `cmdReady` is high, `dacData` is 0 and `dacSel` is 0.
- R2: A write command (op 0 to 3) drives `dacData` from `cmdData` and `dacSel` from op bit 0 (0 = channel A, 1 = channel B). In the same cycle it pulls `dacCsN` low, and `dacCsN` stays low for exactly CS cycles (12 by default).
- R3: `dacData` and `dacSel` change only in the cycle after a write command is accepted. They stay unchanged through the data hold of DH cycles after `dacCsN` rises, and between commands.
- R4: After a plain write (op 0 or 1), `cmdReady` is low for exactly CS + DH cycles (17 by default), starting in the cycle after acceptance.
- R5: For a write-and-load (op 2 or 3), only the selected channel's load strobe falls, max(DH, LS) cycles after `dacCsN` rises (5 by default). It stays low for LW cycles (8).
- R6: A single-channel load (op 4 or 5) pulls only that channel's strobe low for LW cycles, beginning the cycle after acceptance. It leaves `dacCsN` high and the bus data unchanged.
- R7: A load-both command (op 6) lowers both load strobes in the same cycle and raises them in the same cycle, after LW cycles.
- R8: After a load strobe rises, `cmdReady` stays low for LH more cycles. A single load is busy for LW + LH = 11 cycles, a write-and-load for CS + max(DH, LS) + LW + LH = 28.
- R9: A reset command (op 7) holds `dacRstN` low for RW cycles (10). `cmdReady` is low for exactly those RW cycles.
- R10: `cmdValid` is ignored while `cmdReady` is low: no extra pulse appears and the bus data does not change.
- R11: `dacCsN` and a load strobe are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Sequencer idle, command accepted when valid |
| cmdOp | input | 3 | Command code (see encoding above) |
| cmdData | input | DATA_W | Data word for write commands |
| dacData | output | DATA_W | DAC data bus |
| dacSel | output | 1 | Channel address, 0 = A, 1 = B |
| dacCsN | output | 1 | Active-low chip select |
| dacLdAN | output | 1 | Active-low load strobe, channel A |
| dacLdBN | output | 1 | Active-low load strobe, channel B |
| dacRstN | output | 1 | Active-low DAC reset pulse |

## Verification
The bench measures every strobe pulse as it ends and compares its kind, width, data and gap against a queue of expected pulses. This catches a chip select that is one cycle short (an off-by-one counter reload), or a write-and-load that asserts the strobe before the setup gap. A combined load that lowers the two strobes in different cycles shows up as two single-channel records where one was expected. A command offered while busy is checked for leaking through: a sequencer that samples `cmdValid` in a busy state would emit an unexpected reset pulse or stretch the busy time. The data bus is checked during the hold window after chip select rises, and again after a load-only command, to catch a bus that is released or reloaded too early.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    OP_WR_A   = 3'd0,
    OP_WR_B   = 3'd1,
    OP_WRLD_A = 3'd2,
    OP_WRLD_B = 3'd3,
    OP_LD_A   = 3'd4,
    OP_LD_B   = 3'd5,
    OP_LD_AB  = 3'd6,
    OP_RESET  = 3'd7
  } seqOp_t;

  // Strobes from the control FSM to the bus datapath
  typedef struct packed {
    logic busLoad;
    logic csFall;
    logic csRise;
    logic ldFallA;
    logic ldFallB;
    logic ldRise;
    logic rstFall;
    logic rstRise;
  } seqStrobe_t;

  // ceil(ns*1000/periodPs), never below one cycle
  function automatic int nsToCyc(input int ns, input int periodPs);
    int c;
    c = (ns * 1000 + periodPs - 1) / periodPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int CS_CYC  = 12,
  parameter int DH_CYC  = 5,
  parameter int PLD_CYC = 5,
  parameter int LDW_CYC = 8,
  parameter int LDH_CYC = 3,
  parameter int RST_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output logic       cmdReady,
  output seqStrobe_t stb
);

  localparam int MAX_CYC = maxInt(maxInt(maxInt(CS_CYC, DH_CYC), maxInt(PLD_CYC, LDW_CYC)),
                                  maxInt(LDH_CYC, RST_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CSLOW, ST_POSTCS, ST_LDLOW, ST_LDGAP, ST_RSTLOW
  } seqState_t;

  seqState_t  state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic wantLoad, wantLoadNxt;
  logic selA, selANxt, selB, selBNxt;
  seqOp_t op;

  assign op       = seqOp_t'(cmdOp);
  assign cmdReady = (state == ST_IDLE);

  always_comb begin
    stb         = '0;
    stateNxt    = state;
    cntNxt      = cnt;
    wantLoadNxt = wantLoad;
    selANxt     = selA;
    selBNxt     = selB;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          unique case (op)
            OP_WR_A, OP_WR_B, OP_WRLD_A, OP_WRLD_B: begin
              stb.busLoad = 1'b1;
              stb.csFall  = 1'b1;
              cntNxt      = CNT_W'(CS_CYC - 1);
              wantLoadNxt = (op == OP_WRLD_A) || (op == OP_WRLD_B);
              selANxt     = (op == OP_WRLD_A);
              selBNxt     = (op == OP_WRLD_B);
              stateNxt    = ST_CSLOW;
            end
            OP_LD_A, OP_LD_B, OP_LD_AB: begin
              stb.ldFallA = (op != OP_LD_B);
              stb.ldFallB = (op != OP_LD_A);
              cntNxt      = CNT_W'(LDW_CYC - 1);
              stateNxt    = ST_LDLOW;
            end
            default: begin
              stb.rstFall = 1'b1;
              cntNxt      = CNT_W'(RST_CYC - 1);
              stateNxt    = ST_RSTLOW;
            end
          endcase
        end
      end
      ST_CSLOW: begin
        if (cnt == '0) begin
          stb.csRise = 1'b1;
          cntNxt     = wantLoad ? CNT_W'(PLD_CYC - 1) : CNT_W'(DH_CYC - 1);
          stateNxt   = ST_POSTCS;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_POSTCS: begin
        if (cnt == '0) begin
          if (wantLoad) begin
            stb.ldFallA = selA;
            stb.ldFallB = selB;
            cntNxt      = CNT_W'(LDW_CYC - 1);
            stateNxt    = ST_LDLOW;
          end else begin
            stateNxt = ST_IDLE;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_LDLOW: begin
        if (cnt == '0) begin
          stb.ldRise = 1'b1;
          cntNxt     = CNT_W'(LDH_CYC - 1);
          stateNxt   = ST_LDGAP;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_LDGAP: begin
        if (cnt == '0) stateNxt = ST_IDLE;
        else           cntNxt   = cnt - 1'b1;
      end
      ST_RSTLOW: begin
        if (cnt == '0) begin
          stb.rstRise = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      wantLoad <= 1'b0;
      selA     <= 1'b0;
      selB     <= 1'b0;
    end else begin
      state    <= stateNxt;
      cnt      <= cntNxt;
      wantLoad <= wantLoadNxt;
      selA     <= selANxt;
      selB     <= selBNxt;
    end
  end

endmodule

// File: rtl/dac_seq_dpath.sv
module dac_seq_dpath
  import dac_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        stb,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdSel,
  output logic [DATA_W-1:0] dacData,
  output logic              dacSel,
  output logic              dacCsN,
  output logic              dacLdAN,
  output logic              dacLdBN,
  output logic              dacRstN
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dacData <= '0;
      dacSel  <= 1'b0;
    end else if (stb.busLoad) begin
      dacData <= cmdData;
      dacSel  <= cmdSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dacCsN  <= 1'b1;
      dacLdAN <= 1'b1;
      dacLdBN <= 1'b1;
      dacRstN <= 1'b1;
    end else begin
      if (stb.csFall)       dacCsN <= 1'b0;
      else if (stb.csRise)  dacCsN <= 1'b1;
      if (stb.ldFallA)      dacLdAN <= 1'b0;
      else if (stb.ldRise)  dacLdAN <= 1'b1;
      if (stb.ldFallB)      dacLdBN <= 1'b0;
      else if (stb.ldRise)  dacLdBN <= 1'b1;
      if (stb.rstFall)      dacRstN <= 1'b0;
      else if (stb.rstRise) dacRstN <= 1'b1;
    end
  end

endmodule

// File: rtl/dac_bus_sequencer.sv
module dac_bus_sequencer
  import dac_seq_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int CLK_PERIOD_PS = 4000,
  parameter bit HIGH_SUPPLY   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] dacData,
  output logic              dacSel,
  output logic              dacCsN,
  output logic              dacLdAN,
  output logic              dacLdBN,
  output logic              dacRstN
);

  // Interface minimums in ns, chosen by supply set
  localparam int CSW_NS  = HIGH_SUPPLY ? 35 : 45;
  localparam int ASU_NS  = HIGH_SUPPLY ? 15 : 30;
  localparam int DSU_NS  = HIGH_SUPPLY ? 15 : 30;
  localparam int DHO_NS  = HIGH_SUPPLY ? 10 : 20;
  localparam int LSU_NS  = 20;
  localparam int LHO_NS  = 10;
  localparam int LDW_NS  = 30;
  localparam int RSW_NS  = HIGH_SUPPLY ? 30 : 40;

  localparam int CS_CYC  = maxInt(nsToCyc(CSW_NS, CLK_PERIOD_PS),
                                  maxInt(nsToCyc(ASU_NS, CLK_PERIOD_PS),
                                         nsToCyc(DSU_NS, CLK_PERIOD_PS)));
  localparam int DH_CYC  = nsToCyc(DHO_NS, CLK_PERIOD_PS);
  localparam int PLD_CYC = maxInt(DH_CYC, nsToCyc(LSU_NS, CLK_PERIOD_PS));
  localparam int LDW_CYC = nsToCyc(LDW_NS, CLK_PERIOD_PS);
  localparam int LDH_CYC = nsToCyc(LHO_NS, CLK_PERIOD_PS);
  localparam int RST_CYC = nsToCyc(RSW_NS, CLK_PERIOD_PS);

  seqStrobe_t stb;

  dac_seq_ctrl #(
    .CS_CYC (CS_CYC),
    .DH_CYC (DH_CYC),
    .PLD_CYC(PLD_CYC),
    .LDW_CYC(LDW_CYC),
    .LDH_CYC(LDH_CYC),
    .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdReady(cmdReady),
    .stb     (stb)
  );

  dac_seq_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .cmdData(cmdData),
    .cmdSel (cmdOp[0]),
    .dacData(dacData),
    .dacSel (dacSel),
    .dacCsN (dacCsN),
    .dacLdAN(dacLdAN),
    .dacLdBN(dacLdBN),
    .dacRstN(dacRstN)
  );

endmodule

// File: rtl/dac_seq_chk.sv
module dac_seq_chk #(
  parameter int DATA_W  = 12,
  parameter int CS_CYC  = 12,
  parameter int LDW_CYC = 8,
  parameter int RST_CYC = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [DATA_W-1:0] dacData,
  input logic              dacSel,
  input logic              dacCsN,
  input logic              dacLdAN,
  input logic              dacLdBN,
  input logic              dacRstN
);

  int csRun, ldARun, ldBRun, rstRun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csRun  <= 0;
      ldARun <= 0;
      ldBRun <= 0;
      rstRun <= 0;
    end else begin
      csRun  <= dacCsN  ? 0 : csRun + 1;
      ldARun <= dacLdAN ? 0 : ldARun + 1;
      ldBRun <= dacLdBN ? 0 : ldBRun + 1;
      rstRun <= dacRstN ? 0 : rstRun + 1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> dacCsN && dacLdAN && dacLdBN && dacRstN);

  // R2
  cs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dacCsN) |-> csRun == CS_CYC);

  // R3
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmdReady && cmdValid) |-> ($stable(dacData) && $stable(dacSel)));

  // R4
  busy_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dacCsN || !dacLdAN || !dacLdBN || !dacRstN) |-> !cmdReady);

  // R5
  lda_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dacLdAN) |-> ldARun == LDW_CYC);

  // R5
  ldb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dacLdBN) |-> ldBRun == LDW_CYC);

  // R7
  ld_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dacLdAN && !dacLdBN) |-> (($fell(dacLdAN) && $fell(dacLdBN)) || ($past(!dacLdAN) && $past(!dacLdBN))));

  // R9
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dacRstN) |-> rstRun == RST_CYC);

  // R11
  cs_ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dacCsN |-> (dacLdAN && dacLdBN));

endmodule

bind dac_bus_sequencer dac_seq_chk #(
  .DATA_W (DATA_W),
  .CS_CYC (CS_CYC),
  .LDW_CYC(LDW_CYC),
  .RST_CYC(RST_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmdValid(cmdValid),
  .cmdReady(cmdReady),
  .dacData (dacData),
  .dacSel  (dacSel),
  .dacCsN  (dacCsN),
  .dacLdAN (dacLdAN),
  .dacLdBN (dacLdBN),
  .dacRstN (dacRstN)
);

// File: tb/dac_bus_sequencer_bench.sv
module dac_bus_sequencer_bench;

  localparam int DATA_W = 12;
  localparam int PER_PS = 4000;

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + PER_PS - 1) / PER_PS;
    return (c < 1) ? 1 : c;
  endfunction

  // Low-supply set, computed from the requirement formulas
  localparam int CSC = (cyc(45) > cyc(30)) ? cyc(45) : cyc(30);
  localparam int DHC = cyc(20);
  localparam int LSC = cyc(20);
  localparam int PLC = (DHC > LSC) ? DHC : LSC;
  localparam int LWC = cyc(30);
  localparam int LHC = cyc(10);
  localparam int RWC = cyc(40);

  localparam int K_CS = 0, K_LDA = 1, K_LDB = 2, K_LDAB = 3, K_RST = 4;

  typedef struct {
    int kind;
    int width;
    int gap;
    logic [DATA_W-1:0] data;
    logic sel;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [DATA_W-1:0] cmdData = '0;
  logic cmdReady;
  logic [DATA_W-1:0] dacData;
  logic dacSel, dacCsN, dacLdAN, dacLdBN, dacRstN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  dac_bus_sequencer u_dac_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdData(cmdData), .dacData(dacData), .dacSel(dacSel),
    .dacCsN(dacCsN), .dacLdAN(dacLdAN), .dacLdBN(dacLdBN), .dacRstN(dacRstN)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: measure each pulse as it ends and compare with the queue
  int csRun = 0, ldARun = 0, ldBRun = 0, rstRun = 0, sinceCs = 0, ldGap = 0;
  int holdLeft = 0;
  logic [DATA_W-1:0] heldData;
  logic pCs = 1, pA = 1, pB = 1, pR = 1;
  bit overlap = 0;

  task automatic emit(input int kind, input int width, input int gap);
    expItem_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R10", "unexpected pulse kind", kind, -1);
      return;
    end
    e = expQ.pop_front();
    check(kind == e.kind, e.req, "pulse kind", kind, e.kind);
    check(width == e.width, e.req, "pulse width", width, e.width);
    if (e.gap >= 0) check(gap == e.gap, e.req, "gap after cs rise", gap, e.gap);
    if (kind == K_CS) begin
      check(dacData == e.data, "R2", "data at cs rise", int'(dacData), int'(e.data));
      check(dacSel == e.sel, "R2", "sel at cs rise", int'(dacSel), int'(e.sel));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dacCsN && (!dacLdAN || !dacLdBN)) overlap = 1;
      if (holdLeft > 0) begin
        check(dacData == heldData, "R3", "data during hold", int'(dacData), int'(heldData));
        holdLeft--;
      end
      if ((!dacLdAN && pA) || (!dacLdBN && pB)) ldGap = sinceCs;
      if (!dacLdAN) ldARun++;
      if (!dacLdBN) ldBRun++;
      if (dacLdAN && dacLdBN && !pA && !pB) begin
        emit(K_LDAB, (ldARun == ldBRun) ? ldARun : -99, ldGap);
        ldARun = 0; ldBRun = 0;
      end else if (dacLdAN && !pA) begin
        emit(K_LDA, ldARun, ldGap); ldARun = 0;
      end else if (dacLdBN && !pB) begin
        emit(K_LDB, ldBRun, ldGap); ldBRun = 0;
      end
      if (!dacCsN) begin
        csRun++; sinceCs = 0;
      end else begin
        sinceCs++;
        if (!pCs) begin
          check(!overlap, "R11", "load low during chip select", 1, 0);
          overlap = 0;
          emit(K_CS, csRun, -1);
          csRun = 0;
          heldData = dacData;
          holdLeft = DHC - 1;
        end
      end
      if (!dacRstN) rstRun++;
      else if (!pR) begin
        emit(K_RST, rstRun, -1); rstRun = 0;
      end
      pCs = dacCsN; pA = dacLdAN; pB = dacLdBN; pR = dacRstN;
    end
  end

  function automatic expItem_t mk(input int k, input int w, input int g,
                                  input logic [DATA_W-1:0] d, input logic s, input string r);
    expItem_t e;
    e.kind = k; e.width = w; e.gap = g; e.data = d; e.sel = s; e.req = r;
    return e;
  endfunction

  // Driver: pushes expected pulses, issues the command, measures busy time
  task automatic sendCmd(input logic [2:0] op, input logic [DATA_W-1:0] d,
                         input int busyExp, input string busyReq, input bit noisy);
    int n;
    case (op)
      3'd0, 3'd1: expQ.push_back(mk(K_CS, CSC, -1, d, op[0], "R2"));
      3'd2: begin
        expQ.push_back(mk(K_CS, CSC, -1, d, 1'b0, "R2"));
        expQ.push_back(mk(K_LDA, LWC, PLC, '0, 1'b0, "R5"));
      end
      3'd3: begin
        expQ.push_back(mk(K_CS, CSC, -1, d, 1'b1, "R2"));
        expQ.push_back(mk(K_LDB, LWC, PLC, '0, 1'b0, "R5"));
      end
      3'd4: expQ.push_back(mk(K_LDA, LWC, -1, '0, 1'b0, "R6"));
      3'd5: expQ.push_back(mk(K_LDB, LWC, -1, '0, 1'b0, "R6"));
      3'd6: expQ.push_back(mk(K_LDAB, LWC, -1, '0, 1'b0, "R7"));
      default: expQ.push_back(mk(K_RST, RWC, -1, '0, 1'b0, "R9"));
    endcase
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdOp = op; cmdData = d; cmdValid = 1'b1;
    @(negedge clk);
    n = 0;
    if (noisy) begin
      cmdOp = 3'd7; cmdData = ~d;
    end else begin
      cmdValid = 1'b0;
    end
    while (!cmdReady) begin
      n++;
      if (n >= busyExp - 3) cmdValid = 1'b0;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    check(n == busyExp, busyReq, "busy cycles", n, busyExp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    check(cmdReady && dacCsN && dacLdAN && dacLdBN && dacRstN, "R1", "idle strobes in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(dacData == '0 && dacSel == 1'b0, "R1", "bus after reset", int'(dacData), 0);
    check(cmdReady && dacCsN && dacLdAN && dacLdBN && dacRstN, "R1", "idle after reset", 0, 1);

    sendCmd(3'd0, 12'hABC, CSC + DHC, "R4", 1'b0);
    sendCmd(3'd1, 12'h123, CSC + DHC, "R4", 1'b0);
    sendCmd(3'd2, 12'hFFF, CSC + PLC + LWC + LHC, "R8", 1'b0);
    sendCmd(3'd3, 12'h000, CSC + PLC + LWC + LHC, "R8", 1'b0);
    sendCmd(3'd4, 12'h777, LWC + LHC, "R8", 1'b0);
    // R6: load-only leaves bus data at the last written value
    check(dacData == 12'h000 && dacSel == 1'b1, "R6", "bus after load", int'(dacData), 0);
    sendCmd(3'd5, 12'h777, LWC + LHC, "R8", 1'b0);
    sendCmd(3'd6, 12'h555, LWC + LHC, "R7", 1'b0);
    sendCmd(3'd7, 12'h111, RWC, "R9", 1'b0);
    // R10: a reset command offered while busy must not leak through
    sendCmd(3'd0, 12'h5A5, CSC + DHC, "R10", 1'b1);
    repeat (4) @(negedge clk);
    check(dacData == 12'h5A5, "R10", "bus after busy-time command", int'(dacData), 'h5A5);
    check(dacRstN, "R10", "no reset pulse from busy-time command", int'(dacRstN), 1);
    check(expQ.size() == 0, "R10", "pending expected pulses", expQ.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule